// File: doc/BRIEF.md
# Paper-Tape Block Loader

This block turns a stream of tape frames into memory writes. Bytes arrive on a valid/ready interface. The loader skips blank (zero) frames until it sees a non-zero byte, which is the word count of a block. A pad byte follows the count and is thrown away. Next comes a 16-bit origin address, high byte first. The block then holds the stated number of 16-bit data words, each high byte first, and ends with a 16-bit checksum word. Every data word is written to a 16-bit word memory through an address/data/strobe port, starting at the origin and moving up one address per word.

The loader keeps a running 16-bit sum. The sum starts from the origin and adds each data word. The count and pad bytes are not part of it. At the end of each block the sum is compared with the checksum word on the tape. A load begins with a start pulse. It ends in one of three ways:
- successfully, after a long run of blank frames that follows a completed block, or when the input runs out between blocks;
- with a checksum error, when a block's checksum word does not match the sum;
- with a format error, when the input runs out in the middle of a block.

Top module: `ptape_loader`

## Requirements
- R1: Before any block, zero bytes are consumed without effect. The first non-zero byte is taken as the word count (1 to 255). The byte after the count is discarded, whatever its value.
- R2: The origin and the data words are each sent high byte first. Data word i (from 0) is written with mem_addr = origin + i, and the address wraps from 0xFFFF to 0x0000.
- R3: mem_we is high for exactly one cycle per data word, and in_ready is low in every cycle in which mem_we is high.
- R4: The checksum is the origin plus all data words of the block, modulo 2^16. If the received checksum word differs from it, csum_err is set and in_ready stays low from then on. The words of that block have already been written by that time.
- R5: After at least one block has passed its checksum, 11 consecutive zero bytes end the load with done. A run of 10 or fewer zeros followed by a non-zero byte starts a new block.
- R6: If in_end is high with no valid byte while the loader waits for a count byte, done is set. If the same happens anywhere inside a block (pad, origin, data or checksum byte), fmt_err is set.
- R7: At most one of done, csum_err and fmt_err is high at any time. Each stays high, with in_ready low, until the next start pulse. A start pulse clears all three flags and restarts parsing with the checksum and the zero-run count cleared.
- R8: After reset, in_ready, mem_we, done, csum_err and fmt_err are all low until start is pulsed.
- R9: Before the first block, no number of zero bytes ends the load. A block preceded by 20 zeros loads normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins a new load |
| in_valid | input | 1 | A byte is offered on in_data |
| in_data | input | 8 | Tape frame byte |
| in_end | input | 1 | No more input will arrive |
| in_ready | output | 1 | Loader accepts the offered byte this cycle |
| mem_addr | output | 16 | Memory write address |
| mem_data | output | 16 | Memory write data |
| mem_we | output | 1 | Single-cycle memory write strobe |
| done | output | 1 | Load finished successfully |
| csum_err | output | 1 | Load stopped on a checksum mismatch |
| fmt_err | output | 1 | Input ended inside a block |

## Verification
The memory write for a data word and the arrival of the next tape byte can fall in the same cycle. The bench provokes this on every word: it offers the next byte right after the low byte of a word is accepted, so a valid byte is always waiting while the write strobe fires. A monitor samples each cycle. It judges that in_ready was low whenever mem_we was high, that no two strobes were back to back, and that the held byte was then accepted exactly once, which shows up as the correct sequence of addresses and data in the write log.

// File: rtl/ptape_loader.sv
module ptape_loader #(
  parameter int ZERO_RUN = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_end,
  output logic        in_ready,
  output logic [15:0] mem_addr,
  output logic [15:0] mem_data,
  output logic        mem_we,
  output logic        done,
  output logic        csum_err,
  output logic        fmt_err
);
  localparam int ZW = $clog2(ZERO_RUN + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_SKIP, S_PAD, S_OH, S_OL, S_DH, S_DL, S_WR,
    S_SH, S_SL, S_DONE, S_CERR, S_FERR
  } st_t;

  st_t         st;
  logic [7:0]  cnt, hi;
  logic [15:0] addr, word, sum;
  logic [ZW-1:0] zcnt;
  logic        loaded;
  logic        take;

  assign in_ready = (st == S_SKIP) || (st == S_PAD) || (st == S_OH) || (st == S_OL) ||
                    (st == S_DH) || (st == S_DL) || (st == S_SH) || (st == S_SL);
  assign take     = in_valid && in_ready;
  assign mem_we   = (st == S_WR);
  assign mem_addr = addr;
  assign mem_data = word;
  assign done     = (st == S_DONE);
  assign csum_err = (st == S_CERR);
  assign fmt_err  = (st == S_FERR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      hi <= '0;
      addr <= '0;
      word <= '0;
      sum <= '0;
      zcnt <= '0;
      loaded <= 1'b0;
    end else if (start) begin
      st <= S_SKIP;
      sum <= '0;
      zcnt <= '0;
      loaded <= 1'b0;
    end else if (in_ready && !in_valid && in_end) begin
      st <= (st == S_SKIP) ? S_DONE : S_FERR;
    end else begin
      case (st)
        S_SKIP: if (take) begin
          if (in_data == 8'd0) begin
            if (loaded && zcnt == ZW'(ZERO_RUN - 1)) st <= S_DONE;
            else if (loaded) zcnt <= zcnt + 1'b1;
          end else begin
            cnt <= in_data;
            zcnt <= '0;
            st <= S_PAD;
          end
        end
        S_PAD: if (take) st <= S_OH;
        S_OH: if (take) begin hi <= in_data; st <= S_OL; end
        S_OL: if (take) begin
          addr <= {hi, in_data};
          sum <= {hi, in_data};
          st <= S_DH;
        end
        S_DH: if (take) begin hi <= in_data; st <= S_DL; end
        S_DL: if (take) begin
          word <= {hi, in_data};
          sum <= sum + {hi, in_data};
          st <= S_WR;
        end
        S_WR: begin
          addr <= addr + 16'd1;
          cnt <= cnt - 8'd1;
          st <= (cnt == 8'd1) ? S_SH : S_DH;
        end
        S_SH: if (take) begin hi <= in_data; st <= S_SL; end
        S_SL: if (take) begin
          if ({hi, in_data} == sum) begin
            loaded <= 1'b1;
            zcnt <= '0;
            st <= S_SKIP;
          end else st <= S_CERR;
        end
        default: ;
      endcase
    end
  end

  // R3
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);
  // R3
  we_noready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !in_ready);
  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !start) |=> mem_addr == $past(mem_addr) + 16'd1);
  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((done || csum_err || fmt_err) && !start) |=> $stable({done, csum_err, fmt_err}));
  // R7
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, csum_err, fmt_err}));
endmodule

// File: tb/sim_ptape_loader.sv
module sim_ptape_loader;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, start = 0, in_valid = 0, in_end = 0;
  logic [7:0] in_data = 0;
  logic in_ready, mem_we, done, csum_err, fmt_err;
  logic [15:0] mem_addr, mem_data;

  int total = 0, bad = 0;
  logic [31:0] exp_q[$];
  logic [31:0] log_q[$];
  int r3_viol = 0;
  logic prev_we = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptape_loader u0 (.clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_data(in_data), .in_end(in_end), .in_ready(in_ready), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_we(mem_we), .done(done), .csum_err(csum_err),
    .fmt_err(fmt_err));

  always @(negedge clk) begin
    if (mem_we) begin
      log_q.push_back({mem_addr, mem_data});
      if (in_ready || prev_we) r3_viol++;
    end
    prev_we = mem_we;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(logic [7:0] b);
    @(negedge clk);
    in_valid = 1; in_data = b;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  task automatic zeros(int n);
    for (int i = 0; i < n; i++) send(8'h00);
  endtask

  function automatic logic [15:0] add16(logic [15:0] a, logic [15:0] b);
    return a + b;
  endfunction

  task automatic send_block(logic [15:0] org, int n, bit corrupt, int stop_after);
    logic [15:0] s, a, d;
    int sent;
    sent = 0;
    s = org; a = org;
    send(n[7:0]);
    if (stop_after == 1) return;
    send(8'($urandom));
    if (stop_after == 2) return;
    send(org[15:8]); send(org[7:0]);
    for (int i = 0; i < n; i++) begin
      d = 16'($urandom);
      send(d[15:8]);
      if (stop_after == 3) return;
      send(d[7:0]);
      exp_q.push_back({a, d});
      a = a + 16'd1;
      s = add16(s, d);
    end
    if (corrupt) s = s ^ 16'h0040;
    send(s[15:8]); send(s[7:0]);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic end_input();
    @(negedge clk); in_end = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic check_load(string req, bit e_done, bit e_cerr, bit e_ferr);
    repeat (2) @(negedge clk);
    chk({req, " flags"}, {29'd0, done, csum_err, fmt_err}, {29'd0, e_done, e_cerr, e_ferr});
    chk({req, " ready low after end"}, {31'd0, in_ready}, 32'd0);
    chk({req, " write count"}, log_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < log_q.size(); i++)
      if (log_q[i] !== exp_q[i]) chk({req, " write"}, log_q[i], exp_q[i]);
    chk("R3 strobe/ready", r3_viol, 0);
    exp_q.delete(); log_q.delete();
    in_end = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(7));
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // R8 reset state
    chk("R8 reset", {27'd0, in_ready, mem_we, done, csum_err, fmt_err}, 32'd0);

    // R9 R1 R2 R5 directed: long leading zeros, wrap, 11-zero end
    pulse_start();
    zeros(20);
    send_block(16'h0100, 3, 0, 0);
    zeros(5);
    send_block(16'hFFFE, 4, 0, 0);
    zeros(10);
    chk("R5 not done after 10 zeros", {31'd0, done}, 32'd0);
    send(8'h00);
    check_load("R9 R2 R5 directed", 1, 0, 0);
    repeat (4) @(negedge clk);
    // R7 hold
    chk("R7 done holds", {29'd0, done, csum_err, fmt_err}, 32'd4);

    // R6 end of input with no block
    pulse_start();
    end_input();
    check_load("R6 empty tape", 1, 0, 0);

    // R1 max count
    pulse_start();
    zeros(2);
    send_block(16'h2000, 255, 0, 0);
    end_input();
    check_load("R1 count 255", 1, 0, 0);

    // random loads
    for (int k = 0; k < 20; k++) begin
      int nb;
      nb = 1 + int'($urandom % 3);
      pulse_start();
      zeros(int'($urandom % 16));
      for (int b = 0; b < nb; b++) begin
        send_block(16'($urandom), 1 + int'($urandom % 12), 0, 0);
        if (b != nb - 1) zeros(int'($urandom % 11));
      end
      if ($urandom % 2) zeros(11);
      else end_input();
      check_load("R2 R4 R5 R6 random", 1, 0, 0);
    end

    // R4 checksum error after a good block
    pulse_start();
    send_block(16'h0400, 2, 0, 0);
    send_block(16'h0500, 3, 1, 0);
    repeat (5) @(negedge clk);
    check_load("R4 checksum error", 0, 1, 0);

    // R6 truncated after pad
    pulse_start();
    send_block(16'h0600, 2, 0, 2);
    end_input();
    check_load("R6 cut after pad", 0, 0, 1);

    // R6 truncated mid data word
    pulse_start();
    send_block(16'h0700, 3, 0, 3);
    end_input();
    check_load("R6 cut mid word", 0, 0, 1);

    // R7 start clears flags
    pulse_start();
    #1;
    chk("R7 start clears", {28'd0, in_ready, done, csum_err, fmt_err}, 32'd8);
    zeros(11);
    chk("R9 zeros before block do not end", {31'd0, done}, 32'd0);
    end_input();
    check_load("R7 restart", 1, 0, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule